// File: doc/BRIEF.md
# Display Pipe Power Sequencer

This block steps one display pipe through its power-up and power-down orders. It owns the enable bits of the display plane, the pipe, the PLL oscillator (VCO) and the PLL power gate. It also produces a one-cycle flush strobe after every plane enable change, and two indications that tell the pipe the plane and cursor are off. It reads a pipe-activity status, a PLL-lock status and the enable flags of the sibling pipes, which it needs to decide whether the shared PLL may stop.

A power-down request clears the plane and then the pipe. It waits for the pipe to report idle, and then stops the PLL only when no sibling still depends on it. A power-up request ungates the PLL and holds a settle interval before starting the VCO. It waits a bounded time for lock, except on the third pipe, and then enables the plane, then the pipe. Finally it waits for the pipe to report active. Every wait is counted in clock cycles against a parameter. A wait that runs out ends the sequence with a timeout indication.

Top module: `disp_pipe_pwr_seq`

## Requirements
- R1: After reset the plane, pipe and VCO enables are 0. The power gate, plane-off and cursor-off indications are 1. Flush, done and timeout are 0.
- R2: On power-down a set plane enable is cleared first, with flush high in the same cycle. The pipe enable is cleared in a later cycle, and plane-off and cursor-off are set together with it.
- R3: On power-down, after the pipe enable step, the PLL step waits until pipe_active reads 0. If pipe_active stays 1 for IDLE_LIMIT cycles, the sequence ends with timeout set and the VCO and gate are left unchanged.
- R4: The PLL step clears a set VCO enable and sets the power gate in the same cycle. It does this only when pipe_idx is 1 (the second pipe), or when both sib_first_en and sib_third_en are 0. Otherwise the VCO and gate are left unchanged. The pipe index encodes the first, second and third pipes as 0, 1 and 2, and value 3 is treated as neither 1 nor 2.
- R5: On power-up with the VCO off and the gate set, the gate is cleared. The VCO enable rises exactly SETTLE_CYCLES cycles later. With the VCO off and the gate already clear, the VCO is set at once. The VCO enable is never 1 while the gate is 1.
- R6: After the VCO is on, the sequence waits for pll_locked, bounded by LOCK_LIMIT cycles. On expiry it ends with timeout set and the plane and pipe unchanged. With pipe_idx 2 the lock wait is skipped.
- R7: On power-up the plane is enabled (with flush) before the pipe. Enabling the pipe clears plane-off and cursor-off. The sequence then waits for pipe_active to read 1, bounded by IDLE_LIMIT cycles.
- R8: Each sequence ends with done high for exactly one cycle. Timeout rises only together with done, and it holds until the next request is accepted.
- R9: A request is accepted only while no sequence runs. Requests during a sequence have no effect. If on_req and off_req arrive together, power-up wins.
- R10: Steps whose target is already reached are skipped. Enabling a plane that is already on gives no flush, and a VCO that is already running gives no gate change and no settle interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_req | input | 1 | Power-up request |
| off_req | input | 1 | Power-down request |
| pipe_idx | input | 2 | Pipe served by the request (0, 1, 2) |
| sib_first_en | input | 1 | First pipe still enabled |
| sib_third_en | input | 1 | Third pipe still enabled |
| pipe_active | input | 1 | Pipe-state status from the pipe |
| pll_locked | input | 1 | PLL lock status |
| plane_en | output | 1 | Display plane enable |
| pipe_en | output | 1 | Pipe enable |
| plane_off | output | 1 | Plane-off indication to the pipe |
| cursor_off | output | 1 | Cursor-off indication to the pipe |
| vco_en | output | 1 | PLL oscillator enable |
| pll_gate | output | 1 | PLL power gate (1 = gated) |
| flush | output | 1 | One-cycle strobe after a plane enable change |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout | output | 1 | A bounded wait expired in the last sequence |

## Verification
The bench checks the sibling rule for stopping the PLL against every pipe index, including the case where the second pipe stops it regardless of its siblings. A design that checked the siblings for every pipe would leave the second pipe's PLL running. It measures the gap between the gate falling and the VCO rising, which catches an off-by-one settle count or a VCO started while still gated. It drives a pipe that never goes idle and a PLL that never locks, to confirm that the sequence ends, sets timeout and leaves the PLL alone or the plane off. It also confirms that the third pipe does not wait on lock. Requests during a running sequence and simultaneous requests are injected to show that a busy sequencer ignores them and that power-up takes priority.

// File: rtl/dpps_pkg.sv
package dpps_pkg;

    localparam logic [1:0] PIPE_SECOND = 2'd1;
    localparam logic [1:0] PIPE_THIRD  = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OFF_PLANE,
        S_OFF_PIPE,
        S_OFF_WAIT,
        S_OFF_PLL,
        S_ON_START,
        S_ON_SETTLE,
        S_ON_LOCK,
        S_ON_PLANE,
        S_ON_PIPE,
        S_ON_WAIT
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic [1:0] idx;
        logic       plane;
        logic       pipe;
        logic       hide;
        logic       curs;
        logic       vco;
        logic       gate;
        logic       flush;
        logic       done;
        logic       tmo;
    } seq_regs_t;

endpackage

// File: rtl/dpps_wait_timer.sv
module dpps_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == limit - CNT_W'(1));

    always_comb begin
        if (restart)      cnt_d = '0;
        else if (expired) cnt_d = cnt_q;
        else              cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dpps_pipe_rules.sv
module dpps_pipe_rules
    import dpps_pkg::*;
(
    input  logic [1:0] idx,
    input  logic       sib_first_en,
    input  logic       sib_third_en,
    output logic       pll_may_stop,
    output logic       lock_skip
);
    assign pll_may_stop = (idx == PIPE_SECOND) || !(sib_first_en || sib_third_en);
    assign lock_skip    = (idx == PIPE_THIRD);
endmodule

// File: rtl/disp_pipe_pwr_seq.sv
module disp_pipe_pwr_seq
    import dpps_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 63,
    parameter int unsigned LOCK_LIMIT    = 20000,
    parameter int unsigned IDLE_LIMIT    = 32'h1000_0000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_req,
    input  logic       off_req,
    input  logic [1:0] pipe_idx,
    input  logic       sib_first_en,
    input  logic       sib_third_en,
    input  logic       pipe_active,
    input  logic       pll_locked,
    output logic       plane_en,
    output logic       pipe_en,
    output logic       plane_off,
    output logic       cursor_off,
    output logic       vco_en,
    output logic       pll_gate,
    output logic       flush,
    output logic       done,
    output logic       timeout
);
    localparam int unsigned MAX_A = (SETTLE_CYCLES > LOCK_LIMIT) ? SETTLE_CYCLES : LOCK_LIMIT;
    localparam int unsigned MAX_L = (MAX_A > IDLE_LIMIT) ? MAX_A : IDLE_LIMIT;
    localparam int CNT_W = $clog2(MAX_L + 1);

    seq_regs_t        d, q;
    logic             restart, expired, pll_may_stop, lock_skip;
    logic [CNT_W-1:0] limit;

    dpps_pipe_rules u_rules (
        .idx          (q.idx),
        .sib_first_en (sib_first_en),
        .sib_third_en (sib_third_en),
        .pll_may_stop (pll_may_stop),
        .lock_skip    (lock_skip)
    );

    dpps_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .expired (expired)
    );

    always_comb begin
        case (q.state)
            S_ON_SETTLE: limit = CNT_W'(SETTLE_CYCLES);
            S_ON_LOCK:   limit = CNT_W'(LOCK_LIMIT);
            default:     limit = CNT_W'(IDLE_LIMIT);
        endcase
    end

    always_comb begin
        d       = q;
        d.flush = 1'b0;
        d.done  = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (on_req) begin
                    d.state = S_ON_START;
                    d.idx   = pipe_idx;
                    d.tmo   = 1'b0;
                end else if (off_req) begin
                    d.state = S_OFF_PLANE;
                    d.idx   = pipe_idx;
                    d.tmo   = 1'b0;
                end
            end
            S_OFF_PLANE: begin
                if (q.plane) begin
                    d.plane = 1'b0;
                    d.flush = 1'b1;
                end
                d.state = S_OFF_PIPE;
            end
            S_OFF_PIPE: begin
                if (q.pipe) begin
                    d.pipe = 1'b0;
                    d.hide = 1'b1;
                    d.curs = 1'b1;
                end
                d.state = S_OFF_WAIT;
            end
            S_OFF_WAIT: begin
                if (!pipe_active) begin
                    d.state = S_OFF_PLL;
                end else if (expired) begin
                    d.tmo   = 1'b1;
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end
            end
            S_OFF_PLL: begin
                if (q.vco && pll_may_stop) begin
                    d.vco  = 1'b0;
                    d.gate = 1'b1;
                end
                d.done  = 1'b1;
                d.state = S_IDLE;
            end
            S_ON_START: begin
                if (q.vco) begin
                    d.state = lock_skip ? S_ON_PLANE : S_ON_LOCK;
                end else if (q.gate) begin
                    d.gate  = 1'b0;
                    d.state = S_ON_SETTLE;
                end else begin
                    d.vco   = 1'b1;
                    d.state = lock_skip ? S_ON_PLANE : S_ON_LOCK;
                end
            end
            S_ON_SETTLE: begin
                if (expired) begin
                    d.vco   = 1'b1;
                    d.state = lock_skip ? S_ON_PLANE : S_ON_LOCK;
                end
            end
            S_ON_LOCK: begin
                if (pll_locked) begin
                    d.state = S_ON_PLANE;
                end else if (expired) begin
                    d.tmo   = 1'b1;
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end
            end
            S_ON_PLANE: begin
                if (!q.plane) begin
                    d.plane = 1'b1;
                    d.flush = 1'b1;
                end
                d.state = S_ON_PIPE;
            end
            S_ON_PIPE: begin
                if (!q.pipe) begin
                    d.pipe = 1'b1;
                    d.hide = 1'b0;
                    d.curs = 1'b0;
                end
                d.state = S_ON_WAIT;
            end
            S_ON_WAIT: begin
                if (pipe_active) begin
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end else if (expired) begin
                    d.tmo   = 1'b1;
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    assign restart = (d.state != q.state);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= S_IDLE;
            q.idx   <= '0;
            q.plane <= 1'b0;
            q.pipe  <= 1'b0;
            q.hide  <= 1'b1;
            q.curs  <= 1'b1;
            q.vco   <= 1'b0;
            q.gate  <= 1'b1;
            q.flush <= 1'b0;
            q.done  <= 1'b0;
            q.tmo   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign plane_en   = q.plane;
    assign pipe_en    = q.pipe;
    assign plane_off  = q.hide;
    assign cursor_off = q.curs;
    assign vco_en     = q.vco;
    assign pll_gate   = q.gate;
    assign flush      = q.flush;
    assign done       = q.done;
    assign timeout    = q.tmo;

    assert_plane_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(plane_en) |-> flush);
    assert_pipe_off_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pipe_en) |-> (plane_off && cursor_off));
    assert_pll_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> (pll_gate && (q.idx == PIPE_SECOND ||
                           (!$past(sib_first_en) && !$past(sib_third_en)))));
    assert_vco_ungated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vco_en |-> !pll_gate);
    assert_pipe_after_plane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_en) |-> plane_en);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_tmo_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done);
endmodule

// File: tb/disp_pipe_pwr_seq_tb.sv
module disp_pipe_pwr_seq_tb;
    localparam int SETTLE = 5;
    localparam int LOCKL  = 30;
    localparam int IDLEL  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_req = 1'b0, off_req = 1'b0;
    logic [1:0] pipe_idx = 2'd0;
    logic sib_first_en = 1'b0, sib_third_en = 1'b0;
    logic pipe_active, pll_locked;
    logic plane_en, pipe_en, plane_off, cursor_off, vco_en, pll_gate, flush, done, timeout;

    int checks = 0, fails = 0, cyc = 0;
    int act_lat = 2, lock_lat = 3, act_cnt = 0, lock_cnt = 0;

    // results of the last sequence
    int t_gate, t_vco, t_plane, t_pipe, n_flush, n_pchg, len;
    bit flush_ok, hung;

    always #4 clk = ~clk;

    disp_pipe_pwr_seq #(.SETTLE_CYCLES(SETTLE), .LOCK_LIMIT(LOCKL), .IDLE_LIMIT(IDLEL)) u_dut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req), .pipe_idx(pipe_idx),
        .sib_first_en(sib_first_en), .sib_third_en(sib_third_en), .pipe_active(pipe_active),
        .pll_locked(pll_locked), .plane_en(plane_en), .pipe_en(pipe_en), .plane_off(plane_off),
        .cursor_off(cursor_off), .vco_en(vco_en), .pll_gate(pll_gate), .flush(flush),
        .done(done), .timeout(timeout));

    // pipe model: status follows pipe_en after act_lat cycles
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            pipe_active <= 1'b0;
            act_cnt     <= 0;
        end else if (pipe_en != pipe_active) begin
            if (act_cnt >= act_lat) begin
                pipe_active <= pipe_en;
                act_cnt     <= 0;
            end else act_cnt <= act_cnt + 1;
        end else act_cnt <= 0;
        if (!rst_n || !vco_en) lock_cnt <= 0;
        else if (lock_cnt < 1000) lock_cnt <= lock_cnt + 1;
    end
    assign pll_locked = vco_en && (lock_cnt >= lock_lat);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_release(input logic [1:0] idx, input bit s0, input bit s2);
        return (idx == 2'd1) || (!s0 && !s2);
    endfunction

    // issue one request and follow it to done; inject the opposite request at cycle inject
    task automatic run_seq(input bit is_on, input logic [1:0] idx, input bit both, input int inject);
        logic pp, pv, pg, pl;
        int n;
        @(negedge clk);
        pipe_idx = idx;
        on_req   = is_on;
        off_req  = !is_on || both;
        pp = pipe_en; pv = vco_en; pg = pll_gate; pl = plane_en;
        t_gate = -1; t_vco = -1; t_plane = -1; t_pipe = -1;
        n_flush = 0; n_pchg = 0; flush_ok = 1'b1; hung = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            on_req  = 1'b0;
            off_req = 1'b0;
            if (pg && !pll_gate) t_gate = n;
            if (!pv && vco_en) t_vco = n;
            if (pl != plane_en) begin
                t_plane = n;
                n_pchg++;
                if (!flush) flush_ok = 1'b0;
            end
            if (pp != pipe_en) t_pipe = n;
            if (flush) n_flush++;
            pp = pipe_en; pv = vco_en; pg = pll_gate; pl = plane_en;
            if (done) break;
            if (n > 400) begin
                hung = 1'b1;
                break;
            end
            if (n == inject) begin
                on_req  = !is_on;
                off_req = is_on;
            end
        end
        len = n;
        chk(!hung, "R8 sequence reaches done", len, 0);
        @(negedge clk);
        chk(!done, "R8 done lasts one cycle", done, 0);
        chk(flush_ok && n_flush == n_pchg, "R2/R7 flush with each plane change", n_flush, n_pchg);
    endtask

    initial begin
        automatic bit s0, s2, pv, pg, pp, pl, exp_to;
        automatic logic [1:0] idx;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!plane_en && !pipe_en && !vco_en, "R1 enables low after reset", {plane_en, pipe_en, vco_en}, 0);
        chk(pll_gate && plane_off && cursor_off, "R1 gate and off marks high", {pll_gate, plane_off, cursor_off}, 7);
        chk(!flush && !done && !timeout, "R1 strobes low", {flush, done, timeout}, 0);

        // R5 and R7: power-up of first pipe from cold
        act_lat = 2; lock_lat = 3;
        run_seq(1'b1, 2'd0, 1'b0, -1);
        chk(t_vco - t_gate == SETTLE, "R5 settle gap", t_vco - t_gate, SETTLE);
        chk(t_plane > 0 && t_plane < t_pipe, "R7 plane before pipe", t_plane, t_pipe);
        chk(plane_en && pipe_en && vco_en && !pll_gate && !plane_off && !cursor_off && !timeout,
            "R7 pipe up", {plane_en, pipe_en, vco_en, pll_gate, plane_off, cursor_off, timeout}, 7'b1110000);

        // R10: already up, nothing to redo
        run_seq(1'b1, 2'd0, 1'b0, -1);
        chk(n_flush == 0 && t_gate < 0, "R10 no flush and no gate change when up", n_flush, 0);

        // R4: second pipe stops the PLL despite siblings
        sib_first_en = 1'b1; sib_third_en = 1'b1;
        run_seq(1'b0, 2'd1, 1'b0, -1);
        chk(t_plane > 0 && t_plane < t_pipe, "R2 plane cleared before pipe", t_plane, t_pipe);
        chk(!vco_en && pll_gate, "R4 second pipe releases PLL", {vco_en, pll_gate}, 2'b01);
        chk(plane_off && cursor_off && !pipe_en, "R2 off marks set", {plane_off, cursor_off, pipe_en}, 3'b110);

        // R4: first pipe keeps PLL while third pipe runs
        sib_first_en = 1'b0; sib_third_en = 1'b1;
        run_seq(1'b1, 2'd0, 1'b0, -1);
        run_seq(1'b0, 2'd0, 1'b0, -1);
        chk(vco_en && !pll_gate, "R4 sibling keeps PLL running", {vco_en, pll_gate}, 2'b10);
        sib_third_en = 1'b0;

        // R3: pipe never goes idle
        run_seq(1'b1, 2'd0, 1'b0, -1);
        act_lat = 1000;
        run_seq(1'b0, 2'd0, 1'b0, -1);
        chk(timeout && vco_en && !pll_gate, "R3 idle wait timeout leaves PLL", {timeout, vco_en, pll_gate}, 3'b110);
        repeat (3) @(negedge clk);
        chk(timeout, "R8 timeout held while idle", timeout, 1);
        act_lat = 2;
        repeat (5) @(negedge clk);
        run_seq(1'b0, 2'd0, 1'b0, -1);
        chk(!timeout && !vco_en && pll_gate, "R8 timeout cleared by next request", {timeout, vco_en, pll_gate}, 2'b01);

        // R6: lock never arrives on first pipe
        lock_lat = 100;
        run_seq(1'b1, 2'd0, 1'b0, -1);
        chk(timeout && !plane_en && !pipe_en && vco_en, "R6 lock timeout", {timeout, plane_en, pipe_en, vco_en}, 4'b1001);
        run_seq(1'b0, 2'd1, 1'b0, -1);
        // R6: third pipe skips lock wait
        run_seq(1'b1, 2'd2, 1'b0, -1);
        chk(!timeout && plane_en && pipe_en, "R6 third pipe skips lock", {timeout, plane_en, pipe_en}, 3'b011);
        run_seq(1'b0, 2'd1, 1'b0, -1);
        lock_lat = 3;

        // R9: request during a running sequence is ignored
        run_seq(1'b1, 2'd0, 1'b0, 3);
        chk(plane_en && pipe_en && vco_en, "R9 off request while busy ignored", {plane_en, pipe_en, vco_en}, 7);
        repeat (2) @(negedge clk);
        chk(plane_en && pipe_en, "R9 no late sequence", {plane_en, pipe_en}, 3);
        run_seq(1'b0, 2'd1, 1'b1, 4);
        chk(!plane_en && !pipe_en && !vco_en, "R9 on request while busy ignored", {plane_en, pipe_en, vco_en}, 0);
        // R9: simultaneous requests at idle, power-up wins
        run_seq(1'b1, 2'd0, 1'b1, -1);
        chk(plane_en && pipe_en, "R9 on wins over off", {plane_en, pipe_en}, 3);

        // constrained random sequences
        for (int i = 0; i < 24; i++) begin
            automatic bit is_on = $urandom_range(0, 1);
            idx = 2'($urandom_range(0, 3));
            s0 = $urandom_range(0, 1);
            s2 = $urandom_range(0, 1);
            sib_first_en = s0; sib_third_en = s2;
            act_lat = $urandom_range(1, 6);
            pv = vco_en; pg = pll_gate; pp = pipe_en; pl = plane_en;
            exp_to = 1'b0;
            if (is_on && !pv && idx != 2'd2 && $urandom_range(0, 3) == 0) begin
                lock_lat = 100;
                exp_to = 1'b1;
            end else lock_lat = $urandom_range(1, 8);
            run_seq(is_on, idx, 1'b0, -1);
            if (is_on) begin
                chk(vco_en && !pll_gate, "R5 random VCO on", {vco_en, pll_gate}, 2'b10);
                chk(timeout == exp_to, "R6 random lock timeout", timeout, exp_to);
                if (!pv && pg) chk(t_vco - t_gate == SETTLE, "R5 random settle gap", t_vco - t_gate, SETTLE);
                if (exp_to) chk(plane_en == pl && pipe_en == pp, "R6 random untouched", {plane_en, pipe_en}, {pl, pp});
                else chk(plane_en && pipe_en && !plane_off, "R7 random up", {plane_en, pipe_en, plane_off}, 3'b110);
            end else begin
                chk(!plane_en && !pipe_en && plane_off && cursor_off && !timeout, "R2 random down",
                    {plane_en, pipe_en, plane_off, cursor_off, timeout}, 5'b00110);
                chk(vco_en == (pv && !exp_release(idx, s0, s2)), "R4 random VCO",
                    vco_en, pv && !exp_release(idx, s0, s2));
                chk(pll_gate == (pg || (pv && exp_release(idx, s0, s2))), "R4 random gate",
                    pll_gate, pg || (pv && exp_release(idx, s0, s2)));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule